// File: doc/BRIEF.md
# Data Bus Grant Qualifier

This block sits on the master side of a pipelined processor bus. It decides in which cycle a data tenure may begin. Each transfer start places an address tenure into a small pending store. Address acknowledges mark those tenures acknowledged in address order. The cycle after an acknowledge is the retry window. A retry seen in that window removes the tenure. A clean window makes the tenure eligible for its data phase.

The external data bus grant becomes a qualified grant only when four things hold: the grant is present, an eligible tenure is selected, that tenure passed its window without retry, and the data bus is free. The bus counts as free once the current owner has taken its next-to-last beat. The qualified grant is a one-cycle pulse that carries the slot index of the tenure it starts. A beat tracker follows the transfer acknowledges, reports which slot owns the data bus, and frees the slot on the final beat. When the write-reorder input is high, the oldest eligible write may start ahead of an older pending read. Each data tenure needs its own grant pulse; tenures are never streamed.

Top module: `dbus_grant_qual`

## Requirements
- R1: While and after reset, with no stimulus, `go_o` and `own_valid_o` are 0.
- R2: In a cycle where `dbg_i` is 0, `go_o` is 0.
- R3: A tenure can be granted only after three steps: its `ts_i` cycle, an `aack_i` cycle, and a retry-window cycle without `artry_i`. With `ts_i` in cycle c, `aack_i` in c+1 and `dbg_i` held high, `go_o` is 0 through c+2 and first rises in c+3.
- R4: If `artry_i` is high in the cycle after the acknowledge of a tenure, that tenure is removed and is never granted.
- R5: While an owner holds the bus and has not yet received its next-to-last beat, `go_o` stays 0.
- R6: A burst is 4 beats and a single is 1 beat. A new grant may issue once the owner has taken 3 beats (burst) or from the cycle after its own grant (single). Only one granted tenure may wait behind the owner.
- R7: With `wr_bypass_i` low, tenures are granted strictly in `ts_i` order. If the oldest ungranted tenure is not yet eligible, nothing is granted.
- R8: With `wr_bypass_i` high, the oldest eligible write is granted before any older read. With no eligible write, the R7 order applies.
- R9: `go_o` lasts one cycle per grant. `go_idx_o` gives the granted slot, and each tenure is granted at most once.
- R10: The cycle after a grant to an idle bus, `own_valid_o` is 1 and `own_idx_o` equals the granted index. The final beat (4th for a burst, 1st for a single) frees the slot and hands the bus to the waiting tenure, or else clears `own_valid_o`. `ta_i` with no owner has no effect.
- R11: `ts_i` takes the lowest-numbered free slot and is ignored when all 4 slots are in use. `aack_i` applies to the oldest unacknowledged tenure and is ignored when none exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ts_i | input | 1 | Transfer start, queues an address tenure |
| ts_write_i | input | 1 | Tenure is a write (1) or read (0) |
| ts_burst_i | input | 1 | Tenure is a 4-beat burst (1) or single beat (0) |
| aack_i | input | 1 | Address acknowledge, opens the retry window |
| artry_i | input | 1 | Address retry, sampled in the window cycle |
| dbg_i | input | 1 | External data bus grant |
| wr_bypass_i | input | 1 | Let an eligible write overtake older reads |
| ta_i | input | 1 | Transfer acknowledge beat for the owner |
| go_o | output | 1 | Qualified grant pulse |
| go_idx_o | output | 2 | Slot index started by go_o |
| own_valid_o | output | 1 | A tenure owns the data bus |
| own_idx_o | output | 2 | Slot index of the owner |

## Verification
`go_o` and `go_idx_o` are combinational from `dbg_i` and registered queue state. The bench therefore checks them in the same cycle the grant is driven. A retry-window outcome first affects `go_o` in the cycle after the window. `own_valid_o` and `own_idx_o` change one edge after a grant or after a final beat. The bench drives inputs on the falling edge and samples two time units later. Each expected value is written against the cycle in which its register has already been updated.

// File: rtl/dbq_pkg.sv
package dbq_pkg;
  typedef struct packed {
    logic vld;
    logic wr;
    logic burst;
    logic acked;
    logic clean;
    logic started;
  } slot_t;
endpackage

// File: rtl/dbq_slots.sv
module dbq_slots
  import dbq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IW    = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        ts_i,
  input  logic                        ts_write_i,
  input  logic                        ts_burst_i,
  input  logic                        aack_i,
  input  logic                        artry_i,
  input  logic                        go_i,
  input  logic [IW-1:0]               go_idx_i,
  input  logic                        rel_i,
  input  logic [IW-1:0]               rel_idx_i,
  output logic [DEPTH-1:0]            vld_o,
  output logic [DEPTH-1:0]            wr_o,
  output logic [DEPTH-1:0]            burst_o,
  output logic [DEPTH-1:0]            pend_o,
  output logic [DEPTH-1:0]            elig_o,
  output logic [DEPTH-1:0][DEPTH-1:0] older_o,
  output logic                        win_o,
  output logic [IW-1:0]               win_idx_o
);
  slot_t                        slot_q [DEPTH];
  logic [DEPTH-1:0][DEPTH-1:0]  older_q;
  logic                         win_q;
  logic [IW-1:0]                win_idx_q;
  logic [DEPTH-1:0]             free, unacked, old_unacked;
  logic                         alloc_ok, ack_ok;
  logic [IW-1:0]                alloc_idx, ack_idx;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      vld_o[i]   = slot_q[i].vld;
      wr_o[i]    = slot_q[i].wr;
      burst_o[i] = slot_q[i].burst;
      pend_o[i]  = slot_q[i].vld & ~slot_q[i].started;
      elig_o[i]  = slot_q[i].vld & slot_q[i].clean & ~slot_q[i].started;
    end
  end

  assign older_o   = older_q;
  assign win_o     = win_q;
  assign win_idx_o = win_idx_q;
  assign free      = ~vld_o;
  assign alloc_ok  = ts_i & (|free);

  // lowest free slot
  always_comb begin
    alloc_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (free[i]) alloc_idx = IW'(i);
  end

  // address acknowledges follow queue age
  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      unacked[i] = slot_q[i].vld & ~slot_q[i].acked;
    for (int i = 0; i < DEPTH; i++)
      old_unacked[i] = unacked[i] & ~(|(unacked & older_q[i]));
    ack_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (old_unacked[i]) ack_idx = IW'(i);
  end

  assign ack_ok = aack_i & (|unacked);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      older_q   <= '0;
      win_q     <= 1'b0;
      win_idx_q <= '0;
    end else begin
      win_q     <= ack_ok;
      win_idx_q <= ack_idx;
      for (int i = 0; i < DEPTH; i++) begin
        if (win_q && win_idx_q == IW'(i)) begin
          if (artry_i) slot_q[i].vld   <= 1'b0;
          else         slot_q[i].clean <= 1'b1;
        end
        if (ack_ok && ack_idx == IW'(i))     slot_q[i].acked   <= 1'b1;
        if (go_i && go_idx_i == IW'(i))      slot_q[i].started <= 1'b1;
        if (rel_i && rel_idx_i == IW'(i))    slot_q[i].vld     <= 1'b0;
        if (alloc_ok) older_q[i][alloc_idx] <= 1'b0;
        if (alloc_ok && alloc_idx == IW'(i)) begin
          slot_q[i]  <= '{vld: 1'b1, wr: ts_write_i, burst: ts_burst_i,
                          acked: 1'b0, clean: 1'b0, started: 1'b0};
          older_q[i] <= vld_o;
        end
      end
    end
  end
endmodule

// File: rtl/dbq_pick.sv
module dbq_pick #(
  parameter int DEPTH = 4,
  parameter int IW    = 2
) (
  input  logic [DEPTH-1:0]            pend_i,
  input  logic [DEPTH-1:0]            elig_i,
  input  logic [DEPTH-1:0]            wr_i,
  input  logic [DEPTH-1:0][DEPTH-1:0] older_i,
  input  logic                        bypass_i,
  output logic                        cand_o,
  output logic [IW-1:0]               cand_idx_o
);
  logic [DEPTH-1:0] ewr, head, head_wr;
  logic [IW-1:0]    head_idx, wr_idx;

  assign ewr = elig_i & wr_i;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      head[i]    = pend_i[i] & ~(|(pend_i & older_i[i]));
      head_wr[i] = ewr[i] & ~(|(ewr & older_i[i]));
    end
    head_idx = '0;
    wr_idx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (head[i])    head_idx = IW'(i);
      if (head_wr[i]) wr_idx   = IW'(i);
    end
  end

  always_comb begin
    if (bypass_i && (|ewr)) begin
      cand_o     = 1'b1;
      cand_idx_o = wr_idx;
    end else begin
      // strict order: only the oldest ungranted tenure may start
      cand_o     = |(head & elig_i);
      cand_idx_o = head_idx;
    end
  end
endmodule

// File: rtl/dbq_owner.sv
module dbq_owner #(
  parameter int IW    = 2,
  parameter int BEATS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [IW-1:0] go_idx_i,
  input  logic          go_burst_i,
  input  logic          ta_i,
  output logic          ready_o,
  output logic          rel_o,
  output logic [IW-1:0] rel_idx_o,
  output logic          own_v_o,
  output logic [IW-1:0] own_idx_o
);
  localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic          cur_v_q, cur_burst_q, nxt_v_q, nxt_burst_q;
  logic [IW-1:0] cur_idx_q, nxt_idx_q;
  logic [CW-1:0] cnt_q, last;
  logic          ntl, fin;

  assign last      = cur_burst_q ? CW'(BEATS - 1) : '0;
  assign ntl       = cur_v_q && (cnt_q == last);
  assign fin       = ntl && ta_i;
  assign ready_o   = !cur_v_q || (ntl && !nxt_v_q);
  assign rel_o     = fin;
  assign rel_idx_o = cur_idx_q;
  assign own_v_o   = cur_v_q;
  assign own_idx_o = cur_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_v_q     <= 1'b0;
      cur_burst_q <= 1'b0;
      cur_idx_q   <= '0;
      nxt_v_q     <= 1'b0;
      nxt_burst_q <= 1'b0;
      nxt_idx_q   <= '0;
      cnt_q       <= '0;
    end else if (fin) begin
      cnt_q <= '0;
      if (nxt_v_q) begin
        cur_idx_q   <= nxt_idx_q;
        cur_burst_q <= nxt_burst_q;
        nxt_v_q     <= 1'b0;
      end else if (go_i) begin
        cur_idx_q   <= go_idx_i;
        cur_burst_q <= go_burst_i;
      end else begin
        cur_v_q <= 1'b0;
      end
    end else begin
      if (cur_v_q && ta_i) cnt_q <= cnt_q + CW'(1);
      if (go_i) begin
        if (cur_v_q) begin
          nxt_v_q     <= 1'b1;
          nxt_idx_q   <= go_idx_i;
          nxt_burst_q <= go_burst_i;
        end else begin
          cur_v_q     <= 1'b1;
          cur_idx_q   <= go_idx_i;
          cur_burst_q <= go_burst_i;
          cnt_q       <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/dbus_grant_qual.sv
module dbus_grant_qual #(
  parameter int DEPTH       = 4,
  parameter int BURST_BEATS = 4,
  localparam int IW         = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ts_i,
  input  logic          ts_write_i,
  input  logic          ts_burst_i,
  input  logic          aack_i,
  input  logic          artry_i,
  input  logic          dbg_i,
  input  logic          wr_bypass_i,
  input  logic          ta_i,
  output logic          go_o,
  output logic [IW-1:0] go_idx_o,
  output logic          own_valid_o,
  output logic [IW-1:0] own_idx_o
);
  logic [DEPTH-1:0]            slot_vld, slot_wr, slot_burst, slot_pend, slot_elig;
  logic [DEPTH-1:0][DEPTH-1:0] slot_older;
  logic                        win_q, cand, ready, rel;
  logic [IW-1:0]               win_idx, cand_idx, rel_idx;

  dbq_slots #(.DEPTH(DEPTH), .IW(IW)) u_slots (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ts_i       (ts_i),
    .ts_write_i (ts_write_i),
    .ts_burst_i (ts_burst_i),
    .aack_i     (aack_i),
    .artry_i    (artry_i),
    .go_i       (go_o),
    .go_idx_i   (go_idx_o),
    .rel_i      (rel),
    .rel_idx_i  (rel_idx),
    .vld_o      (slot_vld),
    .wr_o       (slot_wr),
    .burst_o    (slot_burst),
    .pend_o     (slot_pend),
    .elig_o     (slot_elig),
    .older_o    (slot_older),
    .win_o      (win_q),
    .win_idx_o  (win_idx)
  );

  dbq_pick #(.DEPTH(DEPTH), .IW(IW)) u_pick (
    .pend_i     (slot_pend),
    .elig_i     (slot_elig),
    .wr_i       (slot_wr),
    .older_i    (slot_older),
    .bypass_i   (wr_bypass_i),
    .cand_o     (cand),
    .cand_idx_o (cand_idx)
  );

  dbq_owner #(.IW(IW), .BEATS(BURST_BEATS)) u_owner (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (go_o),
    .go_idx_i   (go_idx_o),
    .go_burst_i (slot_burst[go_idx_o]),
    .ta_i       (ta_i),
    .ready_o    (ready),
    .rel_o      (rel),
    .rel_idx_o  (rel_idx),
    .own_v_o    (own_valid_o),
    .own_idx_o  (own_idx_o)
  );

  assign go_o     = dbg_i & cand & ready;
  assign go_idx_o = cand_idx;
endmodule

// File: rtl/dbq_chk.sv
module dbq_chk #(
  parameter int DEPTH = 4,
  parameter int IW    = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dbg_i,
  input logic             artry_i,
  input logic             go_o,
  input logic [IW-1:0]    go_idx_o,
  input logic             own_valid_o,
  input logic [IW-1:0]    own_idx_o,
  input logic             win_q,
  input logic [IW-1:0]    win_idx,
  input logic [DEPTH-1:0] slot_vld
);
  // R2
  grant_needs_dbg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> dbg_i);

  // R3
  grant_live_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> slot_vld[go_idx_o]);

  // R4
  retry_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q && artry_i) |=> !slot_vld[$past(win_idx)]);

  // R9
  single_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |=> !(go_o && go_idx_o == $past(go_idx_o)));

  // R10
  owner_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o && !own_valid_o) |=> (own_valid_o && own_idx_o == $past(go_idx_o)));
endmodule

bind dbus_grant_qual dbq_chk #(.DEPTH(DEPTH), .IW(IW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dbg_i       (dbg_i),
  .artry_i     (artry_i),
  .go_o        (go_o),
  .go_idx_o    (go_idx_o),
  .own_valid_o (own_valid_o),
  .own_idx_o   (own_idx_o),
  .win_q       (win_q),
  .win_idx     (win_idx),
  .slot_vld    (slot_vld)
);

// File: tb/sim_dbus_grant_qual.sv
module sim_dbus_grant_qual;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_ni;
  logic ts_i, ts_write_i, ts_burst_i, aack_i, artry_i, dbg_i, wr_bypass_i, ta_i;
  logic go_o, own_valid_o;
  logic [1:0] go_idx_o, own_idx_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  dbus_grant_qual u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ts_i(ts_i), .ts_write_i(ts_write_i),
    .ts_burst_i(ts_burst_i), .aack_i(aack_i), .artry_i(artry_i), .dbg_i(dbg_i),
    .wr_bypass_i(wr_bypass_i), .ta_i(ta_i), .go_o(go_o), .go_idx_o(go_idx_o),
    .own_valid_o(own_valid_o), .own_idx_o(own_idx_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // {ts,wr,burst,aack,artry,dbg,bypass,ta} {go,go_idx,own_v,own_idx}
  localparam logic [13:0] VEC [10] = '{
    14'b10100000_000000,  // burst read -> slot0
    14'b00010000_000000,  // aack
    14'b00000000_000000,  // clean window
    14'b00000100_100000,  // grant slot0
    14'b11000101_000100,  // single write -> slot1, beat1
    14'b00010101_000100,  // aack slot1, beat2
    14'b00000101_000100,  // beat3, window slot1
    14'b00000101_101100,  // final beat, back-to-back grant slot1
    14'b00000001_000101,  // slot1 single final beat
    14'b00000000_000000
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input logic ts, wr, bu, ak, ar, dg, by, ta);
    @(negedge clk);
    ts_i = ts; ts_write_i = wr; ts_burst_i = bu; aack_i = ak;
    artry_i = ar; dbg_i = dg; wr_bypass_i = by; ta_i = ta;
    #2;
  endtask

  task automatic idle();
    tick(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // two singles (read slot0, write slot1) acked and clean
  task automatic load_rd_wr();
    tick(1, 0, 0, 0, 0, 0, 0, 0);
    tick(1, 1, 0, 1, 0, 0, 0, 0);
    tick(0, 0, 0, 1, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    ts_i = 0; ts_write_i = 0; ts_burst_i = 0; aack_i = 0;
    artry_i = 0; dbg_i = 0; wr_bypass_i = 0; ta_i = 0;
    #(CLK_PERIOD * 2 + 1);
    check("R1 go in reset", int'(go_o), 0);
    check("R1 own in reset", int'(own_valid_o), 0);
    @(negedge clk); rst_ni = 1'b1;
    idle();
    check("R1 go after reset", int'(go_o), 0);
    check("R1 own after reset", int'(own_valid_o), 0);

    // table: R6 burst back-to-back, R10 ownership
    for (int k = 0; k < 10; k++) begin
      tick(VEC[k][13], VEC[k][12], VEC[k][11], VEC[k][10],
           VEC[k][9], VEC[k][8], VEC[k][7], VEC[k][6]);
      check($sformatf("R6 table row %0d go", k), int'(go_o), int'(VEC[k][5]));
      if (VEC[k][5]) check($sformatf("R9 table row %0d idx", k), int'(go_idx_o), int'(VEC[k][4:3]));
      check($sformatf("R10 table row %0d own", k), int'(own_valid_o), int'(VEC[k][2]));
      if (VEC[k][2]) check($sformatf("R10 table row %0d own_idx", k), int'(own_idx_o), int'(VEC[k][1:0]));
    end

    // R3, R2, R9: dbg held from ts cycle
    tick(1, 0, 0, 0, 0, 1, 0, 0);
    check("R3 go at ts", int'(go_o), 0);
    tick(0, 0, 0, 1, 0, 1, 0, 0);
    check("R3 go at aack", int'(go_o), 0);
    tick(0, 0, 0, 0, 0, 1, 0, 0);
    check("R3 go in window", int'(go_o), 0);
    tick(0, 0, 0, 0, 0, 0, 0, 0);
    check("R2 go with dbg low", int'(go_o), 0);
    tick(0, 0, 0, 0, 0, 1, 0, 1);
    check("R10 ta with no owner", int'(own_valid_o), 0);
    check("R9 go pulse", int'(go_o), 1);
    check("R9 go idx", int'(go_idx_o), 0);
    tick(0, 0, 0, 0, 0, 1, 0, 1);
    check("R9 no second grant", int'(go_o), 0);
    check("R10 owner idx", int'(own_idx_o), 0);
    idle();
    check("R10 released after single beat", int'(own_valid_o), 0);

    // R4: retried tenure never granted
    tick(1, 0, 1, 0, 0, 0, 0, 0);
    tick(0, 0, 0, 1, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 1, 0, 0, 0);
    for (int k = 0; k < 3; k++) begin
      tick(0, 0, 0, 0, 0, 1, 0, 0);
      check("R4 retried not granted", int'(go_o), 0);
    end
    idle();
    check("R4 no owner after retry", int'(own_valid_o), 0);

    // R7: in order with bypass low
    load_rd_wr();
    tick(0, 0, 0, 0, 0, 1, 0, 0);
    check("R7 read first", int'(go_o), 1);
    check("R7 read idx", int'(go_idx_o), 0);
    tick(0, 0, 0, 0, 0, 1, 0, 0);
    check("R7 write second", int'(go_o), 1);
    check("R7 write idx", int'(go_idx_o), 1);
    tick(0, 0, 0, 0, 0, 0, 0, 1);
    tick(0, 0, 0, 0, 0, 0, 0, 1);
    check("R10 handoff to waiting", int'(own_idx_o), 1);
    idle();
    check("R10 drained", int'(own_valid_o), 0);

    // R8: bypass lets write overtake
    load_rd_wr();
    tick(0, 0, 0, 0, 0, 1, 1, 0);
    check("R8 write overtakes", int'(go_o), 1);
    check("R8 write idx", int'(go_idx_o), 1);
    tick(0, 0, 0, 0, 0, 1, 1, 0);
    check("R8 read follows", int'(go_o), 1);
    check("R8 read idx", int'(go_idx_o), 0);
    check("R10 owner is write", int'(own_idx_o), 1);
    tick(0, 0, 0, 0, 0, 1, 1, 1);
    check("R6 only one waiting", int'(go_o), 0);
    tick(0, 0, 0, 0, 0, 0, 0, 1);
    check("R10 read now owns", int'(own_idx_o), 0);
    idle();
    check("R10 drained after bypass", int'(own_valid_o), 0);

    // R5: burst owner blocks until 3 beats
    tick(1, 0, 1, 0, 0, 0, 0, 0);
    tick(1, 1, 0, 1, 0, 0, 0, 0);
    tick(0, 0, 0, 1, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 1, 0, 0);
    check("R5 burst granted", int'(go_o), 1);
    tick(0, 0, 0, 0, 0, 1, 0, 0);
    check("R5 busy no beats", int'(go_o), 0);
    for (int k = 0; k < 3; k++) begin
      tick(0, 0, 0, 0, 0, 1, 0, 1);
      check("R5 busy before third beat", int'(go_o), 0);
    end
    tick(0, 0, 0, 0, 0, 1, 0, 0);
    check("R6 grant after third beat", int'(go_o), 1);
    check("R6 grant idx", int'(go_idx_o), 1);
    tick(0, 0, 0, 0, 0, 0, 0, 1);
    tick(0, 0, 0, 0, 0, 0, 0, 1);
    check("R10 single owner after burst", int'(own_idx_o), 1);
    idle();
    check("R10 drained after burst", int'(own_valid_o), 0);

    // R11: five starts, four slots
    for (int k = 0; k < 5; k++) tick(1, 1, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 5; k++) tick(0, 0, 0, 1, 0, 0, 0, 0);
    idle();
    for (int k = 0; k < 5; k++) begin
      tick(0, 0, 0, 0, 0, 1, 0, k > 0);
      if (k < 4) begin
        check("R11 grant", int'(go_o), 1);
        check("R11 slot order", int'(go_idx_o), k);
      end else begin
        check("R11 fifth start ignored", int'(go_o), 0);
      end
    end
    tick(0, 0, 0, 0, 0, 1, 0, 0);
    check("R11 nothing left", int'(go_o), 0);
    check("R10 drained at end", int'(own_valid_o), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule